// File: doc/BRIEF.md
# OLED Panel Boot and Window Sequencer

This block brings a 128x128 colour OLED controller out of power-up over a write-only serial link. It has four wires: select, clock, data out and a command/data flag. It also has an active-low panel reset output. An internal step table holds four kinds of step: opcode bytes, argument bytes, timed pauses and pin-setting steps. The steps run in sequence without help from a processor. A pulse on `start_init` plays the complete boot script. A pulse on `start_window` plays only the short script that sets the drawing window to the full panel and opens frame-memory writes.

Pauses are given in milliseconds and turned into clock cycles from the `CLK_FREQ` parameter. While a pause runs, the serial lines stay idle. When a script ends, `done` rises for one clock cycle. The boot script leaves the flag line in data mode so that pixel bytes can follow straight away.

Top module: `oled_boot_seq`

## Requirements
- R1: While `arst_n` is low and after it is released, `spi_cs_n`=1, `panel_rst_n`=1, `spi_sck`=0, `spi_dc`=1 and `done`=0.
- R2: The boot script starts with the following steps, in order:
  - a pause of 50 ms with select inactive;
  - `spi_dc` driven low and `panel_rst_n` held low for 18 ms, with select still inactive;
  - reset released and select activated in the same cycle;
  - a further 50 ms pause before the first clock edge.
- R3: The serial link works as follows:
  - it runs in mode 0 and sends the most significant bit first;
  - `spi_sck` is low while idle, and its high and low phases each last ceil(CLK_FREQ/40e6) cycles, with a minimum of 1, so the period is never below 50 ns;
  - `spi_mosi` is stable while `spi_sck` is high;
  - select stays active for every bit of a script.
- R4: Opcode bytes are sent with `spi_dc`=0 and argument bytes with `spi_dc`=1, and `spi_dc` does not change within a byte.
- R5: The first five bytes of the boot stream are opcode 0xFD, argument 0x12, opcode 0xFD, argument 0xB1, and then opcode 0xAE.
- R6: Opcode 0xB8 is followed by exactly 63 argument bytes. Byte i (0..62) equals 5 + i + floor(113*i*i/3844), so the bytes rise from 0x05 to 0xB4.
- R7: The argument that follows opcode 0xB5 (stream byte 22) is 0x00 when `GPIO_HIGH`=0 and 0x03 when `GPIO_HIGH`=1.
- R8: The boot script ends as follows:
  - it sends opcode 0xAF and then opcode 0x5C;
  - it pauses 50 ms with select still active and no clock activity;
  - it releases select and leaves `spi_dc`=1 and `panel_rst_n`=1.
- R9: `done` is high for exactly one cycle at the end of each script.
- R10: A start request of either kind that arrives while a script is running is ignored, so the stream is neither lengthened nor restarted.
- R11: The window script consists of the following steps:
  - it activates select;
  - it sends opcode 0x15 with arguments 0x00 and 0x7F;
  - it sends opcode 0x75 with arguments 0x00 and 0x7F;
  - it sends opcode 0x5C;
  - it releases select and leaves `spi_dc`=1.
- R12: No serial clock edge occurs during a pause.
- R13: The 110-byte boot stream is as follows:
  - the unlock bytes of R5;
  - opcodes with arguments: B3:F1, CA:7F, A0:B4, 15:00,7F, 75:00,7F, A1:00, A2:00, B5:(R7), AB:01, B1:32, B4:A0,B5,55, BB:17, BE:05, C1:C8,80,C8, C7:0F and B6:01;
  - opcode A6;
  - opcode B8 with the arguments of R6;
  - the two opcodes of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| start_init | input | 1 | Pulse: run the complete boot script |
| start_window | input | 1 | Pulse: run the window-setup script |
| panel_rst_n | output | 1 | Active-low reset to the panel |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_dc | output | 1 | 0 = opcode byte, 1 = argument/data byte |
| done | output | 1 | One-cycle pulse when a script ends |

## Verification
The assertions check local invariants on every cycle:
- the clock stays low while select is inactive;
- data is held while the clock is high;
- the flag line is held within a byte;
- no shifting happens during a pause;
- select is inactive while the panel is in reset;
- `done` lasts a single cycle.

The byte content and ordering of both scripts can only be shown by the bench's scenarios, which decode the serial stream and compare it with a list rebuilt from the requirements. The same holds for the length of each pause, the GPIO variant and the rejection of start requests made mid-script.

// File: rtl/oled_boot_pkg.sv
package oled_boot_pkg;

  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_ARG  = 3'd1,
    ST_WAIT = 3'd2,
    ST_PINS = 3'd3,
    ST_END  = 3'd4
  } step_kind_e;

  // arg meaning: byte for OPC/ARG, milliseconds for WAIT,
  // {dc, rst_n, cs_n} in bits [2:0] for PINS
  typedef struct packed {
    step_kind_e kind;
    logic [7:0] arg;
  } step_t;

  localparam int PIN_CS = 0;
  localparam int PIN_RST = 1;
  localparam int PIN_DC = 2;

  function automatic step_t opc(input logic [7:0] b);
    return '{kind: ST_OPC, arg: b};
  endfunction

  function automatic step_t prm(input logic [7:0] b);
    return '{kind: ST_ARG, arg: b};
  endfunction

  function automatic step_t pause_ms(input logic [7:0] ms);
    return '{kind: ST_WAIT, arg: ms};
  endfunction

  function automatic step_t pins(input logic dc, input logic rstn, input logic csn);
    return '{kind: ST_PINS, arg: {5'd0, dc, rstn, csn}};
  endfunction

  // Grayscale curve: linear ramp plus quadratic bend, 0x05 .. 0xB4
  function automatic logic [7:0] gray_level(input int i);
    int v;
    v = 5 + i + (113 * i * i) / 3844;
    return v[7:0];
  endfunction

  function automatic int cyc_per_ms(input int clk_freq);
    int c;
    c = clk_freq / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // half SCK period in clocks so that the full period is >= 50 ns
  function automatic int sck_half(input int clk_freq);
    int h;
    h = (clk_freq + 39_999_999) / 40_000_000;
    return (h < 1) ? 1 : h;
  endfunction

endpackage

// File: rtl/oled_step_rom.sv
module oled_step_rom
  import oled_boot_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter bit GPIO_HIGH = 1'b0
) (
  input  logic [PC_W-1:0] idx,
  output step_t           step
);
  localparam logic [7:0] GPIO_ARG = GPIO_HIGH ? 8'h03 : 8'h00;
  localparam int GRAY_LO = 51;
  localparam int GRAY_HI = GRAY_LO + 62;

  always_comb begin
    step = '{kind: ST_END, arg: 8'h00};
    if (int'(idx) >= GRAY_LO && int'(idx) <= GRAY_HI) begin
      step = prm(gray_level(int'(idx) - GRAY_LO));
    end else begin
      case (int'(idx))
        0:   step = pins(1'b1, 1'b1, 1'b1);
        1:   step = pause_ms(8'd50);
        2:   step = pins(1'b0, 1'b0, 1'b1);
        3:   step = pause_ms(8'd18);
        4:   step = pins(1'b0, 1'b1, 1'b0);
        5:   step = pause_ms(8'd50);
        6:   step = opc(8'hFD);
        7:   step = prm(8'h12);
        8:   step = opc(8'hFD);
        9:   step = prm(8'hB1);
        10:  step = opc(8'hAE);
        11:  step = opc(8'hB3);
        12:  step = prm(8'hF1);
        13:  step = opc(8'hCA);
        14:  step = prm(8'h7F);
        15:  step = opc(8'hA0);
        16:  step = prm(8'hB4);
        17:  step = opc(8'h15);
        18:  step = prm(8'h00);
        19:  step = prm(8'h7F);
        20:  step = opc(8'h75);
        21:  step = prm(8'h00);
        22:  step = prm(8'h7F);
        23:  step = opc(8'hA1);
        24:  step = prm(8'h00);
        25:  step = opc(8'hA2);
        26:  step = prm(8'h00);
        27:  step = opc(8'hB5);
        28:  step = prm(GPIO_ARG);
        29:  step = opc(8'hAB);
        30:  step = prm(8'h01);
        31:  step = opc(8'hB1);
        32:  step = prm(8'h32);
        33:  step = opc(8'hB4);
        34:  step = prm(8'hA0);
        35:  step = prm(8'hB5);
        36:  step = prm(8'h55);
        37:  step = opc(8'hBB);
        38:  step = prm(8'h17);
        39:  step = opc(8'hBE);
        40:  step = prm(8'h05);
        41:  step = opc(8'hC1);
        42:  step = prm(8'hC8);
        43:  step = prm(8'h80);
        44:  step = prm(8'hC8);
        45:  step = opc(8'hC7);
        46:  step = prm(8'h0F);
        47:  step = opc(8'hB6);
        48:  step = prm(8'h01);
        49:  step = opc(8'hA6);
        50:  step = opc(8'hB8);
        114: step = opc(8'hAF);
        115: step = opc(8'h5C);
        116: step = pause_ms(8'd50);
        117: step = pins(1'b1, 1'b1, 1'b1);
        118: step = '{kind: ST_END, arg: 8'h00};
        // window-setup script
        119: step = pins(1'b0, 1'b1, 1'b0);
        120: step = opc(8'h15);
        121: step = prm(8'h00);
        122: step = prm(8'h7F);
        123: step = opc(8'h75);
        124: step = prm(8'h00);
        125: step = prm(8'h7F);
        126: step = opc(8'h5C);
        127: step = pins(1'b1, 1'b1, 1'b1);
        default: step = '{kind: ST_END, arg: 8'h00};
      endcase
    end
  end
endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx #(
  parameter int HALF = 1
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       fin
);
  localparam int DIV_W = $clog2(HALF + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

  logic [7:0]       sh;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] div;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh   <= 8'h00;
      bitn <= 3'd0;
      div  <= '0;
      sck  <= 1'b0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !busy) begin
        sh   <= data;
        bitn <= 3'd0;
        div  <= '0;
        sck  <= 1'b0;
        busy <= 1'b1;
      end else if (busy) begin
        if (div == DIV_LAST) begin
          div <= '0;
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end else begin
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 3'd1;
            end
          end
        end else begin
          div <= div + DIV_W'(1);
        end
      end
    end
  end

  assign mosi = sh[7];
endmodule

// File: rtl/oled_delay_timer.sv
module oled_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= count;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/oled_boot_seq.sv
module oled_boot_seq
  import oled_boot_pkg::*;
#(
  parameter int CLK_FREQ  = 50_000_000,
  parameter bit GPIO_HIGH = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start_init,
  input  logic start_window,
  output logic panel_rst_n,
  output logic spi_cs_n,
  output logic spi_sck,
  output logic spi_mosi,
  output logic spi_dc,
  output logic done
);
  localparam int CPM   = cyc_per_ms(CLK_FREQ);
  localparam int HALF  = sck_half(CLK_FREQ);
  localparam int CNT_W = $clog2(255 * CPM + 1);
  localparam int PC_W  = 8;
  localparam logic [PC_W-1:0] INIT_PC = PC_W'(0);
  localparam logic [PC_W-1:0] WIN_PC  = PC_W'(119);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SHIFT, S_WAIT} seq_e;

  seq_e            state;
  logic [PC_W-1:0] pc;
  step_t           step;
  logic            tx_load, tx_busy, tx_fin;
  logic            tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_count;

  // named events for the checker
  logic in_wait, running, step_end;
  assign in_wait  = (state == S_WAIT);
  assign running  = (state != S_IDLE);
  assign step_end = (state == S_FETCH) && (step.kind == ST_END);

  oled_step_rom #(.PC_W(PC_W), .GPIO_HIGH(GPIO_HIGH)) u_rom (
    .idx (pc),
    .step(step)
  );

  assign tx_load   = (state == S_FETCH) && (step.kind == ST_OPC || step.kind == ST_ARG);
  assign tmr_load  = (state == S_FETCH) && (step.kind == ST_WAIT);
  assign tmr_count = CNT_W'(int'(step.arg) * CPM);

  oled_spi_tx #(.HALF(HALF)) u_tx (
    .clk   (clk),
    .arst_n(arst_n),
    .load  (tx_load),
    .data  (step.arg),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .busy  (tx_busy),
    .fin   (tx_fin)
  );

  oled_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .arst_n(arst_n),
    .load  (tmr_load),
    .count (tmr_count),
    .expire(tmr_expire)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state       <= S_IDLE;
      pc          <= INIT_PC;
      panel_rst_n <= 1'b1;
      spi_cs_n    <= 1'b1;
      spi_dc      <= 1'b1;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_init) begin
            pc    <= INIT_PC;
            state <= S_FETCH;
          end else if (start_window) begin
            pc    <= WIN_PC;
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          case (step.kind)
            ST_OPC, ST_ARG: begin
              spi_dc <= (step.kind == ST_ARG);
              pc     <= pc + PC_W'(1);
              state  <= S_SHIFT;
            end
            ST_WAIT: begin
              pc    <= pc + PC_W'(1);
              state <= S_WAIT;
            end
            ST_PINS: begin
              spi_cs_n    <= step.arg[PIN_CS];
              panel_rst_n <= step.arg[PIN_RST];
              spi_dc      <= step.arg[PIN_DC];
              pc          <= pc + PC_W'(1);
            end
            default: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_SHIFT: if (tx_fin) state <= S_FETCH;
        S_WAIT:  if (tmr_expire) state <= S_FETCH;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oled_boot_seq_chk.sv
module oled_boot_seq_chk (
  input logic clk,
  input logic arst_n,
  input logic panel_rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic spi_dc,
  input logic done,
  input logic tx_busy,
  input logic in_wait,
  input logic step_end
);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!arst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_dc_steady_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(spi_dc));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);

  assert_done_follows_end_R9: assert property (@(posedge clk) disable iff (!arst_n)
    step_end |=> done);

  assert_quiet_pause_R12: assert property (@(posedge clk) disable iff (!arst_n)
    in_wait |-> (!spi_sck && !tx_busy));

  assert_reset_deselect_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !panel_rst_n |-> spi_cs_n);
endmodule

bind oled_boot_seq oled_boot_seq_chk i_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .panel_rst_n(panel_rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .spi_dc     (spi_dc),
  .done       (done),
  .tx_busy    (tx_busy),
  .in_wait    (in_wait),
  .step_end   (step_end)
);

// File: tb/test_oled_boot_seq.sv
module spi_capture (
  input logic clr,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic dc
);
  logic [8:0] rec [0:255];
  int n;
  int cs_bad;
  int dc_flip;
  int bits;
  logic [7:0] sh;
  logic dc0;

  always @(posedge sck or posedge clr) begin
    if (clr) begin
      n = 0; cs_bad = 0; dc_flip = 0; bits = 0; sh = 8'h00; dc0 = 1'b0;
    end else begin
      if (cs_n) cs_bad = cs_bad + 1;
      if (bits == 0) dc0 = dc;
      else if (dc !== dc0) dc_flip = dc_flip + 1;
      sh = {sh[6:0], mosi};
      bits = bits + 1;
      if (bits == 8) begin
        if (n < 256) rec[n] = {dc0, sh};
        n = n + 1;
        bits = 0;
      end
    end
  end
endmodule

module test_oled_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ = 4000;          // 4 cycles per millisecond
  localparam int CPM = FREQ / 1000;
  localparam int HALF_EXP = 1;
  localparam int SLACK = 8;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic start_init = 1'b0, start_window = 1'b0;
  logic clr = 1'b0;
  logic rst_a, cs_a, sck_a, mosi_a, dc_a, done_a;
  logic rst_b, cs_b, sck_b, mosi_b, dc_b, done_b;

  int total = 0, bad = 0;
  logic [8:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  oled_boot_seq #(.CLK_FREQ(FREQ), .GPIO_HIGH(1'b0)) i_oled_boot_seq (
    .clk(clk), .arst_n(arst_n), .start_init(start_init), .start_window(start_window),
    .panel_rst_n(rst_a), .spi_cs_n(cs_a), .spi_sck(sck_a), .spi_mosi(mosi_a),
    .spi_dc(dc_a), .done(done_a));

  oled_boot_seq #(.CLK_FREQ(FREQ), .GPIO_HIGH(1'b1)) i_oled_boot_seq_gh (
    .clk(clk), .arst_n(arst_n), .start_init(start_init), .start_window(start_window),
    .panel_rst_n(rst_b), .spi_cs_n(cs_b), .spi_sck(sck_b), .spi_mosi(mosi_b),
    .spi_dc(dc_b), .done(done_b));

  spi_capture cap_a (.clr(clr), .cs_n(cs_a), .sck(sck_a), .mosi(mosi_a), .dc(dc_a));
  spi_capture cap_b (.clr(clr), .cs_n(cs_b), .sck(sck_b), .mosi(mosi_b), .dc(dc_b));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  task automatic o(input logic [7:0] b); exp_q.push_back({1'b0, b}); endtask
  task automatic a(input logic [7:0] b); exp_q.push_back({1'b1, b}); endtask

  task automatic build_init(input logic [7:0] g);
    exp_q.delete();
    o(8'hFD); a(8'h12); o(8'hFD); a(8'hB1); o(8'hAE);
    o(8'hB3); a(8'hF1); o(8'hCA); a(8'h7F); o(8'hA0); a(8'hB4);
    o(8'h15); a(8'h00); a(8'h7F); o(8'h75); a(8'h00); a(8'h7F);
    o(8'hA1); a(8'h00); o(8'hA2); a(8'h00); o(8'hB5); a(g);
    o(8'hAB); a(8'h01); o(8'hB1); a(8'h32);
    o(8'hB4); a(8'hA0); a(8'hB5); a(8'h55);
    o(8'hBB); a(8'h17); o(8'hBE); a(8'h05);
    o(8'hC1); a(8'hC8); a(8'h80); a(8'hC8);
    o(8'hC7); a(8'h0F); o(8'hB6); a(8'h01); o(8'hA6); o(8'hB8);
    for (int i = 0; i < 63; i++) begin
      int v;
      v = 5 + i + (113 * i * i) / 3844;
      a(v[7:0]);
    end
    o(8'hAF); o(8'h5C);
  endtask

  function automatic string tag_of(input int k);
    if (k < 5) return "R5";
    if (k == 22) return "R7";
    if (k >= 45 && k <= 107) return "R6";
    if (k >= 108) return "R8";
    return "R13";
  endfunction

  task automatic compare_a(input string req_all);
    chk(cap_a.n == exp_q.size(), req_all, cap_a.n, exp_q.size());
    for (int k = 0; k < exp_q.size() && k < cap_a.n; k++)
      chk(cap_a.rec[k] == exp_q[k], tag_of(k), int'(cap_a.rec[k]), int'(exp_q[k]));
    chk(cap_a.cs_bad == 0, "R3 cs active on every bit", cap_a.cs_bad, 0);
    chk(cap_a.dc_flip == 0, "R4 dc steady in byte", cap_a.dc_flip, 0);
  endtask

  initial begin
    int c, t_rst_fall, t_rst_rise, t_cs_fall, t_first_sck, t_last_fall, t_cs_rise;
    int done_cnt, done_len, sck_run, sck_run_bad, dc_in_reset;
    bit fin_a, fin_b;
    logic p_rst, p_cs, p_sck;

    clr = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk(cs_a == 1'b1 && rst_a == 1'b1 && sck_a == 1'b0 && dc_a == 1'b1 && done_a == 1'b0,
        "R1 in reset", {cs_a, rst_a, sck_a, dc_a, done_a}, 5'b11010);
    arst_n = 1'b1;
    clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_a == 1'b1 && rst_a == 1'b1 && sck_a == 1'b0 && dc_a == 1'b1 && done_a == 1'b0,
        "R1 after reset", {cs_a, rst_a, sck_a, dc_a, done_a}, 5'b11010);

    // ---------------- boot script ----------------
    t_rst_fall = -1; t_rst_rise = -1; t_cs_fall = -1; t_first_sck = -1;
    t_last_fall = -1; t_cs_rise = -1; done_cnt = 0; done_len = 0;
    sck_run = 0; sck_run_bad = 0; dc_in_reset = -1;
    fin_a = 1'b0; fin_b = 1'b0;
    p_rst = rst_a; p_cs = cs_a; p_sck = sck_a;
    c = 0;
    while (!(fin_a && fin_b) && c < 20000) begin
      if (p_rst && !rst_a) begin t_rst_fall = c; dc_in_reset = int'(dc_a); end
      if (!p_rst && rst_a) t_rst_rise = c;
      if (p_cs && !cs_a && t_cs_fall < 0) t_cs_fall = c;
      if (!p_cs && cs_a && c > 1) t_cs_rise = c;
      if (!p_sck && sck_a && t_first_sck < 0) t_first_sck = c;
      if (p_sck && !sck_a) t_last_fall = c;
      if (sck_a) sck_run++;
      else begin
        if (p_sck && sck_run != HALF_EXP) sck_run_bad++;
        sck_run = 0;
      end
      if (done_a) begin done_len++; if (done_cnt == 0 || !fin_a) done_cnt++; fin_a = 1'b1; end
      if (done_b) fin_b = 1'b1;
      p_rst = rst_a; p_cs = cs_a; p_sck = sck_a;
      // drive after sampling
      start_init   = (c == 0) || (c == 400) || (c == 900);
      start_window = (c == 400) || (c == 1500);
      c++;
      @(negedge clk);
    end
    start_init = 1'b0; start_window = 1'b0;
    repeat (4) @(negedge clk);
    if (done_a) done_len++;
    chk(c < 20000, "R9 boot watchdog", c, 20000);

    chk(t_rst_fall >= 50 * CPM && t_rst_fall <= 50 * CPM + SLACK, "R2 pre-reset pause", t_rst_fall, 50 * CPM);
    chk(t_rst_rise - t_rst_fall >= 18 * CPM && t_rst_rise - t_rst_fall <= 18 * CPM + SLACK,
        "R2 reset low width", t_rst_rise - t_rst_fall, 18 * CPM);
    chk(dc_in_reset == 0, "R2 dc low during reset", dc_in_reset, 0);
    chk(t_cs_fall == t_rst_rise, "R2 select with reset release", t_cs_fall, t_rst_rise);
    chk(t_first_sck - t_cs_fall >= 50 * CPM && t_first_sck - t_cs_fall <= 50 * CPM + SLACK,
        "R12 pause before first clock", t_first_sck - t_cs_fall, 50 * CPM);
    chk(t_cs_rise - t_last_fall >= 50 * CPM && t_cs_rise - t_last_fall <= 50 * CPM + SLACK,
        "R8 final pause", t_cs_rise - t_last_fall, 50 * CPM);
    chk(cs_a == 1'b1 && dc_a == 1'b1 && rst_a == 1'b1, "R8 final pins", {cs_a, dc_a, rst_a}, 3'b111);
    chk(done_len == 1, "R9 done width", done_len, 1);
    chk(sck_run_bad == 0, "R3 sck high phase length", sck_run_bad, 0);
    chk(sck_a == 1'b0, "R3 sck idle low", int'(sck_a), 0);

    build_init(8'h00);
    compare_a("R10 boot byte count");
    chk(cap_a.rec[45][7:0] == 8'h05 && cap_a.rec[107][7:0] == 8'hB4, "R6 curve ends",
        int'({cap_a.rec[45][7:0], cap_a.rec[107][7:0]}), 16'h05B4);
    build_init(8'h03);
    chk(cap_b.n == exp_q.size(), "R7 gh byte count", cap_b.n, exp_q.size());
    for (int k = 0; k < exp_q.size() && k < cap_b.n; k++)
      chk(cap_b.rec[k] == exp_q[k], (k == 22) ? "R7" : tag_of(k), int'(cap_b.rec[k]), int'(exp_q[k]));

    // ---------------- window script ----------------
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    start_window = 1'b1;
    @(negedge clk);
    start_window = 1'b0;
    c = 0;
    done_len = 0;
    fin_a = 1'b0;
    while (!fin_a && c < 2000) begin
      if (done_a) begin fin_a = 1'b1; done_len++; end
      start_init = (c == 20);
      c++;
      @(negedge clk);
    end
    start_init = 1'b0;
    if (done_a) done_len++;
    chk(c < 2000, "R11 window watchdog", c, 2000);
    exp_q.delete();
    o(8'h15); a(8'h00); a(8'h7F); o(8'h75); a(8'h00); a(8'h7F); o(8'h5C);
    chk(cap_a.n == 7, "R11 window byte count", cap_a.n, 7);
    for (int k = 0; k < 7 && k < cap_a.n; k++)
      chk(cap_a.rec[k] == exp_q[k], "R11 window byte", int'(cap_a.rec[k]), int'(exp_q[k]));
    chk(cap_a.cs_bad == 0, "R3 window select", cap_a.cs_bad, 0);
    chk(cs_a == 1'b1 && dc_a == 1'b1, "R11 window end pins", {cs_a, dc_a}, 2'b11);
    chk(done_len == 1, "R9 window done width", done_len, 1);
    repeat (300) @(negedge clk);
    chk(cap_a.n == 7, "R10 init request during window ignored", cap_a.n, 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule